// File: doc/BRIEF.md
# Codec Link Reset and Suspend Controller

This block drives the power-state signalling of a serial audio codec link from the fast bus clock. A free-running divider produces a one-cycle tick every quarter microsecond. Two pulse generators count these ticks. The cold-reset generator holds the active-low codec reset line low long enough for the codec to reset. The warm-reset generator holds the frame sync line high long enough for the codec to resume.

A third piece watches the codec's bit clock. It reports the link as suspended once the bit clock has not changed for a set number of bus-clock cycles. The divider never restarts, so the phase of a request against the tick is unknown. For that reason the warm-reset count holds one tick more than the minimum needs.

The bus reset (`rst_n`) starts a cold-reset pulse by itself. A request that arrives while its own pulse is running is dropped.

Top module: `codec_link_pwr_ctrl`

## Requirements
- R1: The divider counts `PRE_RELOAD+1` bus cycles per tick. After reset is released, the ticks fall on bus edges 50, 100, 150 and so on (default parameters). Requests never shift this phase.
- R2: While `rst_n` is low, `codec_rst_n` is 0 and `cold_busy` is 1. After release, `codec_rst_n` stays 0 through bus edge 199 and becomes 1 after edge 200, the fourth tick.
- R3: A `cold_req` that is sampled at edge S while no cold pulse is running pulls `codec_rst_n` low after S. The line goes back high after the `RST_TICKS`-th tick edge that is strictly later than S. This is at least `(RST_TICKS-1)*(PRE_RELOAD+1)+1` cycles.
- R4: A `cold_req` that arrives during a cold pulse neither extends nor restarts that pulse.
- R5: A `resume_req` that is sampled at edge S while idle drives `sync_drive` high after S. The line returns low after the `RES_TICKS`-th tick edge that is strictly later than S. This is at least 201 cycles (1 µs at 200 MHz) with the default parameters.
- R6: A `resume_req` that arrives during a resume pulse neither extends nor restarts that pulse.
- R7: The two generators are independent. A resume request does not touch `codec_rst_n`, a cold request does not touch `sync_drive`, and both can run at the same time. `cold_busy` always equals the inverse of `codec_rst_n`, and `resume_busy` always equals `sync_drive`.
- R8: With `bit_clk` constant, `suspended` becomes 1 exactly `IDLE_LIMIT+3` bus edges after the last change of `bit_clk`. This is 36 edges at the defaults and covers two synchronizer stages plus one edge-detect stage. After reset, with `bit_clk` never changing, it rises after edge 33.
- R9: A change of `bit_clk` in either direction clears `suspended` after the third bus edge that follows the change. A `bit_clk` whose half-period is at most `IDLE_LIMIT` bus cycles never shows `suspended`. A half-period of `IDLE_LIMIT+1` or more does show it.
- R10: While `rst_n` is low, `sync_drive`, `resume_busy` and `suspended` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| cold_req | input | 1 | Request for a cold codec reset |
| resume_req | input | 1 | Request for a warm reset (resume) |
| bit_clk | input | 1 | Codec bit clock, asynchronous to `clk` |
| codec_rst_n | output | 1 | Active-low codec reset |
| sync_drive | output | 1 | Drive high on frame sync for resume |
| suspended | output | 1 | Bit clock has gone quiet |
| cold_busy | output | 1 | Cold-reset pulse in progress |
| resume_busy | output | 1 | Resume pulse in progress |

## Verification
Several properties are checked by assertions on every cycle:
- the tick is never wider than one cycle;
- a pulse generator keeps its tick count whenever no tick arrives, even if a request comes in;
- a pulse can only end on a tick;
- no count goes past its limit;
- a bit-clock edge always clears the suspended flag on the next cycle.

Other behaviour can only be shown by the bench's scenarios, which compare each pulse length with the tick phase the bench tracks itself. These are:
- the exact pulse lengths for requests at a known divider phase;
- the minimum-duration bounds;
- that requests made in mid-pulse are dropped;
- the exact suspend and clear latencies;
- the half-period threshold of the bit clock.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;

  typedef enum logic [0:0] {
    PULSE_IDLE = 1'b0,
    PULSE_HOLD = 1'b1
  } pulse_state_t;

  localparam int DEF_PRE_RELOAD = 49;
  localparam int DEF_RST_TICKS  = 4;
  localparam int DEF_RES_TICKS  = 5;
  localparam int DEF_IDLE_LIMIT = 33;
  localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/lnk_tick_gen.sv
module lnk_tick_gen #(
  parameter int PRE_RELOAD = 49
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(PRE_RELOAD + 2);
  localparam logic [CW-1:0] LAST = CW'(PRE_RELOAD);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1

  generate
    if (PRE_RELOAD > 0) begin : g_width
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end
  endgenerate

endmodule

// File: rtl/lnk_pulse_timer.sv
module lnk_pulse_timer
  import codec_link_pkg::*;
#(
  parameter int TICKS      = 4,
  parameter bit START_BUSY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic busy
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  pulse_state_t  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      PULSE_IDLE: begin
        if (req) begin
          state_d = PULSE_HOLD;
          cnt_d   = '0;
        end
      end
      PULSE_HOLD: begin
        if (tick) begin
          if (cnt_q == LAST) begin
            state_d = PULSE_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = PULSE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= START_BUSY ? PULSE_HOLD : PULSE_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q == PULSE_HOLD);

  AST_HOLD_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> (busy && $stable(cnt_q))); // R4
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick)); // R3
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3
  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (busy && cnt_q == '0)); // R5

endmodule

// File: rtl/lnk_idle_detect.sv
module lnk_idle_detect #(
  parameter int IDLE_LIMIT  = 33,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk,
  output logic suspended
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_LIMIT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;
  logic                   edge_seen;
  logic [CW-1:0]          cnt_q, cnt_d;

  always_comb begin
    edge_seen = sync_q[SYNC_STAGES-1] ^ hist_q;
    if (edge_seen)           cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], bit_clk};
      hist_q <= sync_q[SYNC_STAGES-1];
      cnt_q  <= cnt_d;
    end
  end

  assign suspended = (cnt_q == LIMIT);

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !suspended); // R9
  AST_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> !$past(edge_seen)); // R8
  AST_IDLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R8

endmodule

// File: rtl/codec_link_pwr_ctrl.sv
module codec_link_pwr_ctrl
  import codec_link_pkg::*;
#(
  parameter int PRE_RELOAD  = DEF_PRE_RELOAD,
  parameter int RST_TICKS   = DEF_RST_TICKS,
  parameter int RES_TICKS   = DEF_RES_TICKS,
  parameter int IDLE_LIMIT  = DEF_IDLE_LIMIT,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cold_req,
  input  logic resume_req,
  input  logic bit_clk,
  output logic codec_rst_n,
  output logic sync_drive,
  output logic suspended,
  output logic cold_busy,
  output logic resume_busy
);
  logic tick;

  lnk_tick_gen #(.PRE_RELOAD(PRE_RELOAD)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  lnk_pulse_timer #(.TICKS(RST_TICKS), .START_BUSY(1'b1)) u_cold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(cold_req), .busy(cold_busy)
  );

  lnk_pulse_timer #(.TICKS(RES_TICKS), .START_BUSY(1'b0)) u_resume (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(resume_req), .busy(resume_busy)
  );

  lnk_idle_detect #(.IDLE_LIMIT(IDLE_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_idle (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .suspended(suspended)
  );

  assign codec_rst_n = ~cold_busy;
  assign sync_drive  = resume_busy;

  AST_RESUME_SKIPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && !cold_busy && !cold_req) |=> codec_rst_n); // R7

endmodule

// File: tb/tb_codec_link_pwr_ctrl.sv
module tb_codec_link_pwr_ctrl;
  localparam int P      = 50;
  localparam int NRST   = 4;
  localparam int NRES   = 5;
  localparam int LIM    = 33;
  localparam int NVEC   = 5;
  localparam int VH [NVEC] = '{4, 16, 33, 34, 60};
  localparam int VE [NVEC] = '{0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n, cold_req, resume_req, bit_clk;
  logic codec_rst_n, sync_drive, suspended, cold_busy, resume_busy;
  int   cyc = 0;
  int   total = 0;
  int   checks = 0;
  int   fails = 0;

  always #4 clk = ~clk;

  codec_link_pwr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .resume_req(resume_req),
    .bit_clk(bit_clk), .codec_rst_n(codec_rst_n), .sync_drive(sync_drive),
    .suspended(suspended), .cold_busy(cold_busy), .resume_busy(resume_busy)
  );

  always @(posedge clk) begin
    total <= total + 1;
    if (rst_n) cyc <= cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (total > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", total);
    finish_run();
  end

  // Fire requests at one edge S and measure both pulse lengths in cycles
  task automatic fire(input bit c, input bit r, input int retrig,
                      output int s, output int lc, output int lr, output int mism);
    while (!codec_rst_n || sync_drive) @(negedge clk);
    s = cyc + 1;
    cold_req = c; resume_req = r;
    @(negedge clk);
    lc = 0; lr = 0; mism = 0;
    for (int i = 0; i < 2000; i++) begin
      if (!codec_rst_n) lc++;
      if (sync_drive) lr++;
      if (cold_busy != !codec_rst_n || resume_busy != sync_drive) mism++;
      cold_req   = (i == retrig) ? c : 1'b0;
      resume_req = (i == retrig) ? r : 1'b0;
      if (codec_rst_n && !sync_drive) break;
      @(negedge clk);
    end
    cold_req = 0; resume_req = 0;
  endtask

  function automatic int exp_len(input int s, input int n);
    return ((s / P) + n) * P - s;
  endfunction

  initial begin
    int s, lc, lr, mm, seen;
    rst_n = 0; cold_req = 0; resume_req = 0; bit_clk = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset codec_rst_n", codec_rst_n, 0);
    chk("R2 reset cold_busy", cold_busy, 1);
    chk("R10 reset sync_drive", sync_drive, 0);
    chk("R10 reset resume_busy", resume_busy, 0);
    chk("R10 reset suspended", suspended, 0);
    rst_n = 1;
    for (int n = 1; n <= 200; n++) begin
      @(negedge clk);
      if (n == 32)  chk("R8 quiet after reset edge 32", suspended, 0);
      if (n == 33)  chk("R8 quiet after reset edge 33", suspended, 1);
      if (n == 199) chk("R2 codec reset held at edge 199", codec_rst_n, 0);
      if (n == 200) chk("R2 codec reset released at edge 200", codec_rst_n, 1);
    end

    // R9 / R8 table: bit clock half-period versus suspended seen
    for (int v = 0; v < NVEC; v++) begin
      seen = 0;
      for (int k = 0; k < 8; k++) begin
        bit_clk = ~bit_clk;
        for (int j = 0; j < VH[v]; j++) begin
          @(negedge clk);
          if (k >= 2 && suspended) seen = 1;
        end
      end
      chk($sformatf("R9 half-period %0d suspended seen", VH[v]), seen, VE[v]);
    end

    // R8 exact latency after the last change
    bit_clk = ~bit_clk;
    repeat (LIM + 2) @(negedge clk);
    chk("R8 not yet suspended at LIMIT+2", suspended, 0);
    @(negedge clk);
    chk("R8 suspended at LIMIT+3", suspended, 1);
    // R9 exact clear latency, falling edge of bit clock
    bit_clk = ~bit_clk;
    repeat (2) @(negedge clk);
    chk("R9 still suspended after 2 edges", suspended, 1);
    @(negedge clk);
    chk("R9 cleared after 3 edges", suspended, 0);

    // R3 cold pulse alone
    fire(1, 0, -1, s, lc, lr, mm);
    chk("R3 cold length", lc, exp_len(s, NRST));
    chk("R3 cold minimum", (lc >= (NRST - 1) * P + 1) ? 1 : 0, 1);
    chk("R7 cold leaves sync low", lr, 0);
    chk("R7 busy flags match outputs", mm, 0);
    // R5 resume pulse alone
    repeat (17) @(negedge clk);
    fire(0, 1, -1, s, lc, lr, mm);
    chk("R5 resume length", lr, exp_len(s, NRES));
    chk("R5 resume minimum 1us", (lr >= 4 * P + 1) ? 1 : 0, 1);
    chk("R7 resume leaves codec reset high", lc, 0);
    // R4 cold retrigger ignored
    repeat (3) @(negedge clk);
    fire(1, 0, 100, s, lc, lr, mm);
    chk("R4 cold retrigger ignored", lc, exp_len(s, NRST));
    // R6 resume retrigger ignored
    repeat (29) @(negedge clk);
    fire(0, 1, 150, s, lc, lr, mm);
    chk("R6 resume retrigger ignored", lr, exp_len(s, NRES));
    // R7 both together, R1 phase unaffected by earlier requests
    repeat (11) @(negedge clk);
    fire(1, 1, -1, s, lc, lr, mm);
    chk("R7 joint cold length", lc, exp_len(s, NRST));
    chk("R7 joint resume length", lr, exp_len(s, NRES));
    chk("R1 tick phase kept", (s + lr) % P, 0);
    chk("R7 joint busy flags", mm, 0);

    finish_run();
  end
endmodule